// File: doc/BRIEF.md
# Dual-CPU Shared Memory Select

This block is purely combinational. It produces the chip-select and strobe signals for a system with two processors. A main CPU and a sub CPU share one boot ROM and one common RAM. The sub CPU also owns four private RAM banks. A single source-select input decides which processor's controls reach the shared ROM and the common RAM. When the input is high, which is its idle pulled-up level, the sub CPU owns them. When the input is low, the main CPU owns them.

On the sub CPU side, the block looks at the upper five address bits, 15 down to 11. From them it decodes a boot-ROM window, a common-RAM window and four 2 KB private-bank windows. It then qualifies the output and write enables with the sub CPU's memory request and its read and write strobes.

On the main CPU side, access to the common RAM is granted only while the sub CPU is running and has acknowledged the bus. Every boot-ROM fetch by the main CPU has one ROM address line forced high. This places the main CPU's boot code 4 KB above the sub CPU's boot code.

All memory controls are active low. A write strobe always overrides a read strobe, so no memory ever sees its output enable and its write enable together.

Top module: `dual_cpu_mem_select`

## Requirements
- R1: With `src_sub` low, the ROM and common-RAM outputs follow the main CPU inputs. With `src_sub` high, they follow the sub CPU decode.
- R2: The main CPU is granted the common RAM only when `m_cram_req_n`=0, `sub_rst_n`=1 and `sub_ack_n`=0. Without the grant, `cram_cs_n`, `cram_oe_n` and `cram_we_n` are all 1 while `src_sub`=0.
- R3: While the main CPU holds the grant, `cram_cs_n`=0. `cram_we_n` is 0 when `m_wr_n`=0, and `cram_oe_n` is 0 when `m_rd_n`=0 and `m_wr_n`=1.
- R4: With `src_sub`=0, `rom_ce_n` equals `m_rom_req_n` and `rom_a12` is 1. `rom_oe_n` is 0 only when `m_rom_req_n`=0, `m_rd_n`=0 and `m_wr_n`=1.
- R5: With `src_sub`=1, `rom_ce_n` is 0 exactly when address bits 15..13 are 000, which is 0x0000 to 0x1FFF. `rom_a12` equals address bit 12. `rom_oe_n` is 0 only when `s_mreq_n`=0, `s_rd_n`=0 and `s_wr_n`=1.
- R6: With `src_sub`=1, `cram_cs_n` is 0 exactly when address bits 15..13 are 001, which is 0x2000 to 0x3FFF. `cram_we_n` is 0 when that select holds with `s_mreq_n`=0 and `s_wr_n`=0. `cram_oe_n` is 0 when that select holds with `s_mreq_n`=0, `s_rd_n`=0 and `s_wr_n`=1.
- R7: `bank_cs_n[k]` is 0 when address bits 15..11 equal 8+k and `s_mreq_n`=0 with either strobe low. The bank windows are 0x4000+k*0x800, each 2 KB long, with k=0 for bank A through k=3 for bank D. `bank_oe_n` and `bank_we_n` follow the same read and write rules as R6 for any bank hit.
- R8: Any sub address in 0x6000 to 0xFFFF leaves every bank output at 1. With `src_sub`=1, such an address also leaves every ROM and common-RAM select and strobe at 1.
- R9: When both read and write strobes are low, the write enable wins and the output enable stays 1. No memory ever has OE and WE low together.
- R10: The private-bank outputs depend only on the sub CPU inputs and are unaffected by `src_sub`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sub | input | 1 | Shared-memory owner: 1 selects the sub CPU, 0 selects the main CPU |
| m_rom_req_n | input | 1 | Main CPU boot-ROM select, active low |
| m_cram_req_n | input | 1 | Main CPU common-RAM request, active low |
| m_rd_n | input | 1 | Main CPU read strobe, active low |
| m_wr_n | input | 1 | Main CPU write strobe, active low |
| sub_rst_n | input | 1 | Sub CPU reset line; high means the sub CPU is running |
| sub_ack_n | input | 1 | Sub CPU bus acknowledge, active low |
| s_addr_hi | input | 5 | Sub CPU address bits 15..11 |
| s_mreq_n | input | 1 | Sub CPU memory request, active low |
| s_rd_n | input | 1 | Sub CPU read strobe, active low |
| s_wr_n | input | 1 | Sub CPU write strobe, active low |
| rom_ce_n | output | 1 | Boot ROM chip enable |
| rom_oe_n | output | 1 | Boot ROM output enable |
| rom_a12 | output | 1 | Boot ROM address line 12 |
| cram_cs_n | output | 1 | Common RAM chip select |
| cram_oe_n | output | 1 | Common RAM output enable |
| cram_we_n | output | 1 | Common RAM write enable |
| bank_cs_n | output | 4 | Private bank chip selects; bit k is bank k (A to D) |
| bank_oe_n | output | 1 | Private bank output enable |
| bank_we_n | output | 1 | Private bank write enable |

## Verification
The block holds no state, so any internal fault appears at the ports in the same cycle as the input pattern that exposes it.

A wrong page decode shows as a chip select that is low in the wrong 8 KB or 2 KB window. A broken source mux shows as the main CPU's pattern appearing while `src_sub` is high, or the reverse. A missing grant term shows as a common-RAM select that is low while the sub CPU is held in reset.

Sweeping every 2 KB page against every strobe combination, under both select values, exposes each of these faults the moment its page or strobe pattern is applied.

// File: rtl/dcms_pkg.sv
package dcms_pkg;

  // Controls of the memories whose owner is switched between the two CPUs.
  typedef struct packed {
    logic rom_ce_n;
    logic rom_oe_n;
    logic rom_a12;
    logic cram_cs_n;
    logic cram_oe_n;
    logic cram_we_n;
  } shared_ctl_t;

  localparam int SHARED_W = $bits(shared_ctl_t);

  localparam shared_ctl_t SHARED_IDLE = '{
    rom_ce_n:  1'b1,
    rom_oe_n:  1'b1,
    rom_a12:   1'b1,
    cram_cs_n: 1'b1,
    cram_oe_n: 1'b1,
    cram_we_n: 1'b1
  };

  // Read qualified by request; a low write strobe suppresses it.
  function automatic logic read_ok(input logic req_n, input logic rd_n,
                                   input logic wr_n);
    return !req_n && !rd_n && wr_n;
  endfunction

  function automatic logic write_ok(input logic req_n, input logic wr_n);
    return !req_n && !wr_n;
  endfunction

endpackage

// File: rtl/dcms_main_ctrl.sv
module dcms_main_ctrl
  import dcms_pkg::*;
#(
  parameter logic MAIN_A12_LEVEL = 1'b1
) (
  input  logic        rom_req_n,
  input  logic        cram_req_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        sub_rst_n,
  input  logic        sub_ack_n,
  output shared_ctl_t ctl,
  output logic        grant
);

  logic grant_n;

  assign grant   = !cram_req_n && sub_rst_n && !sub_ack_n;
  assign grant_n = !grant;

  always_comb begin
    ctl           = SHARED_IDLE;
    ctl.rom_ce_n  = rom_req_n;
    ctl.rom_oe_n  = !read_ok(rom_req_n, rd_n, wr_n);
    ctl.rom_a12   = MAIN_A12_LEVEL;
    ctl.cram_cs_n = grant_n;
    ctl.cram_oe_n = !read_ok(grant_n, rd_n, wr_n);
    ctl.cram_we_n = !write_ok(grant_n, wr_n);
  end

endmodule

// File: rtl/dcms_sub_decode.sv
module dcms_sub_decode
  import dcms_pkg::*;
#(
  parameter int TAG_W     = 5,
  parameter int PAGE_W    = 3,
  parameter int A12_IDX   = 1,
  parameter int N_BANKS   = 4,
  parameter int TAG_BASE  = 8,
  parameter logic [PAGE_W-1:0] ROM_PAGE  = '0,
  parameter logic [PAGE_W-1:0] CRAM_PAGE = PAGE_W'(1)
) (
  input  logic [TAG_W-1:0]   tag,
  input  logic               mreq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  output shared_ctl_t        ctl,
  output logic [N_BANKS-1:0] bank_cs_n,
  output logic               bank_oe_n,
  output logic               bank_we_n,
  output logic               rom_hit,
  output logic               cram_hit
);

  logic [PAGE_W-1:0]  page;
  logic [N_BANKS-1:0] bank_hit;
  logic               rd_q;
  logic               wr_q;
  logic               any_bank;

  assign page     = tag[TAG_W-1 -: PAGE_W];
  assign rom_hit  = (page == ROM_PAGE);
  assign cram_hit = (page == CRAM_PAGE);
  assign rd_q     = read_ok(mreq_n, rd_n, wr_n);
  assign wr_q     = write_ok(mreq_n, wr_n);

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    localparam logic [TAG_W-1:0] BANK_TAG = TAG_W'(TAG_BASE + k);
    assign bank_hit[k]  = (tag == BANK_TAG);
    assign bank_cs_n[k] = !(bank_hit[k] && (rd_q || wr_q));
  end

  assign any_bank  = |bank_hit;
  assign bank_oe_n = !(any_bank && rd_q);
  assign bank_we_n = !(any_bank && wr_q);

  always_comb begin
    ctl           = SHARED_IDLE;
    ctl.rom_ce_n  = !rom_hit;
    ctl.rom_oe_n  = !(rom_hit && rd_q);
    ctl.rom_a12   = tag[A12_IDX];
    ctl.cram_cs_n = !cram_hit;
    ctl.cram_oe_n = !(cram_hit && rd_q);
    ctl.cram_we_n = !(cram_hit && wr_q);
  end

endmodule

// File: rtl/dcms_src_mux.sv
module dcms_src_mux #(
  parameter int W = 6
) (
  input  logic         sel_b,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out[i] = sel_b ? in_b[i] : in_a[i];
  end

endmodule

// File: rtl/dual_cpu_mem_select.sv
module dual_cpu_mem_select
  import dcms_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BANK_LSB = 11,
  parameter int ROM_A_BIT = 12,
  parameter int PAGE_W  = 3,
  parameter int N_BANKS = 4,
  parameter logic [ADDR_W-1:0] BANK_BASE_ADDR = 16'h4000,
  localparam int TAG_W  = ADDR_W - BANK_LSB
) (
  input  logic               src_sub,
  input  logic               m_rom_req_n,
  input  logic               m_cram_req_n,
  input  logic               m_rd_n,
  input  logic               m_wr_n,
  input  logic               sub_rst_n,
  input  logic               sub_ack_n,
  input  logic [TAG_W-1:0]   s_addr_hi,
  input  logic               s_mreq_n,
  input  logic               s_rd_n,
  input  logic               s_wr_n,
  output logic               rom_ce_n,
  output logic               rom_oe_n,
  output logic               rom_a12,
  output logic               cram_cs_n,
  output logic               cram_oe_n,
  output logic               cram_we_n,
  output logic [N_BANKS-1:0] bank_cs_n,
  output logic               bank_oe_n,
  output logic               bank_we_n
);

  localparam int TAG_BASE = int'(BANK_BASE_ADDR >> BANK_LSB);
  localparam int A12_IDX  = ROM_A_BIT - BANK_LSB;

  // Named internal events, also observed by the bound checker.
  shared_ctl_t main_ctl;
  shared_ctl_t sub_ctl;
  shared_ctl_t muxed_ctl;
  logic        main_grant;
  logic        sub_rom_hit;
  logic        sub_cram_hit;

  dcms_main_ctrl #(
    .MAIN_A12_LEVEL(1'b1)
  ) u_main (
    .rom_req_n (m_rom_req_n),
    .cram_req_n(m_cram_req_n),
    .rd_n      (m_rd_n),
    .wr_n      (m_wr_n),
    .sub_rst_n (sub_rst_n),
    .sub_ack_n (sub_ack_n),
    .ctl       (main_ctl),
    .grant     (main_grant)
  );

  dcms_sub_decode #(
    .TAG_W   (TAG_W),
    .PAGE_W  (PAGE_W),
    .A12_IDX (A12_IDX),
    .N_BANKS (N_BANKS),
    .TAG_BASE(TAG_BASE)
  ) u_sub (
    .tag      (s_addr_hi),
    .mreq_n   (s_mreq_n),
    .rd_n     (s_rd_n),
    .wr_n     (s_wr_n),
    .ctl      (sub_ctl),
    .bank_cs_n(bank_cs_n),
    .bank_oe_n(bank_oe_n),
    .bank_we_n(bank_we_n),
    .rom_hit  (sub_rom_hit),
    .cram_hit (sub_cram_hit)
  );

  dcms_src_mux #(
    .W(SHARED_W)
  ) u_mux (
    .sel_b(src_sub),
    .in_a (main_ctl),
    .in_b (sub_ctl),
    .out  (muxed_ctl)
  );

  assign rom_ce_n  = muxed_ctl.rom_ce_n;
  assign rom_oe_n  = muxed_ctl.rom_oe_n;
  assign rom_a12   = muxed_ctl.rom_a12;
  assign cram_cs_n = muxed_ctl.cram_cs_n;
  assign cram_oe_n = muxed_ctl.cram_oe_n;
  assign cram_we_n = muxed_ctl.cram_we_n;

endmodule

// File: rtl/dcms_checker.sv
module dcms_checker #(
  parameter int TAG_W    = 5,
  parameter int N_BANKS  = 4,
  parameter int HIGH_TAG = 12
) (
  input logic               src_sub,
  input logic               m_rom_req_n,
  input logic               m_cram_req_n,
  input logic               m_rd_n,
  input logic               m_wr_n,
  input logic               sub_rst_n,
  input logic               sub_ack_n,
  input logic [TAG_W-1:0]   s_addr_hi,
  input logic               s_mreq_n,
  input logic               s_rd_n,
  input logic               s_wr_n,
  input logic               rom_ce_n,
  input logic               rom_oe_n,
  input logic               rom_a12,
  input logic               cram_cs_n,
  input logic               cram_oe_n,
  input logic               cram_we_n,
  input logic [N_BANKS-1:0] bank_cs_n,
  input logic               bank_oe_n,
  input logic               bank_we_n,
  input logic               main_grant,
  input logic               sub_rom_hit,
  input logic               sub_cram_hit
);

  logic high_area;
  logic strobes_idle;

  assign high_area    = (int'(s_addr_hi) >= HIGH_TAG);
  assign strobes_idle = m_rom_req_n & m_rd_n & s_mreq_n & s_rd_n & s_wr_n;

  always_comb begin
    assert_cram_no_overlap_R9: assert (cram_oe_n || cram_we_n)
      else $error("common RAM OE and WE low together");
    assert_bank_no_overlap_R9: assert (bank_oe_n || bank_we_n)
      else $error("bank OE and WE low together");
    assert_rom_oe_in_ce_R5: assert (rom_oe_n || !rom_ce_n)
      else $error("ROM OE low without CE");
    assert_bank_single_R7: assert ($onehot0(~bank_cs_n))
      else $error("more than one bank selected");
    assert_bank_strobe_cs_R7: assert ((bank_oe_n && bank_we_n) || !(&bank_cs_n))
      else $error("bank strobe without a bank select");
    assert_main_a12_R4: assert (src_sub || rom_a12)
      else $error("main ROM fetch without the high ROM line");
    assert_main_gate_R2: assert (src_sub || main_grant || cram_cs_n)
      else $error("common RAM selected for main CPU without grant");
    assert_sub_rom_sel_R5: assert (!src_sub || (rom_ce_n == !sub_rom_hit))
      else $error("sub ROM select does not follow decode");
    assert_sub_cram_sel_R6: assert (!src_sub || (cram_cs_n == !sub_cram_hit))
      else $error("sub common RAM select does not follow decode");
    assert_high_idle_R8: assert (!high_area || ((&bank_cs_n) && bank_oe_n && bank_we_n &&
                                 (!src_sub || (rom_ce_n && rom_oe_n && cram_cs_n &&
                                               cram_oe_n && cram_we_n))))
      else $error("output active above the decoded map");
    assert_idle_gate_R1: assert (!(strobes_idle && !src_sub) || (rom_oe_n && cram_oe_n))
      else $error("main side read active with idle strobes");
    assert_grant_inputs_R2: assert (!main_grant || (sub_rst_n && !sub_ack_n && !m_cram_req_n &&
                                    (m_wr_n | !m_wr_n)))
      else $error("main grant with an invalid condition");
  end

endmodule

bind dual_cpu_mem_select dcms_checker #(
  .TAG_W   (ADDR_W - BANK_LSB),
  .N_BANKS (N_BANKS),
  .HIGH_TAG(int'(BANK_BASE_ADDR >> BANK_LSB) + N_BANKS)
) u_dcms_checker (.*);

// File: tb/tb_dual_cpu_mem_select.sv
`timescale 1ns/1ps
module tb_dual_cpu_mem_select;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       src_sub;
  logic       m_rom_req_n, m_cram_req_n, m_rd_n, m_wr_n, sub_rst_n, sub_ack_n;
  logic [4:0] s_addr_hi;
  logic       s_mreq_n, s_rd_n, s_wr_n;
  logic       rom_ce_n, rom_oe_n, rom_a12, cram_cs_n, cram_oe_n, cram_we_n;
  logic [3:0] bank_cs_n;
  logic       bank_oe_n, bank_we_n;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  dual_cpu_mem_select dut (
    .src_sub(src_sub), .m_rom_req_n(m_rom_req_n), .m_cram_req_n(m_cram_req_n),
    .m_rd_n(m_rd_n), .m_wr_n(m_wr_n), .sub_rst_n(sub_rst_n), .sub_ack_n(sub_ack_n),
    .s_addr_hi(s_addr_hi), .s_mreq_n(s_mreq_n), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_a12(rom_a12),
    .cram_cs_n(cram_cs_n), .cram_oe_n(cram_oe_n), .cram_we_n(cram_we_n),
    .bank_cs_n(bank_cs_n), .bank_oe_n(bank_oe_n), .bank_we_n(bank_we_n)
  );

  // Address map of the sub CPU: region index 0 ROM, 1 common RAM, 2..5 banks A..D.
  localparam logic [15:0] MAP_LO [6] = '{16'h0000, 16'h2000, 16'h4000,
                                         16'h4800, 16'h5000, 16'h5800};
  localparam logic [15:0] MAP_HI [6] = '{16'h1FFF, 16'h3FFF, 16'h47FF,
                                         16'h4FFF, 16'h57FF, 16'h5FFF};

  function automatic int region_of(input logic [15:0] a);
    for (int r = 0; r < 6; r++)
      if (a >= MAP_LO[r] && a <= MAP_HI[r]) return r;
    return -1;
  endfunction

  // Output order: rom_ce, rom_oe, a12, cram_cs, cram_oe, cram_we, bank_cs[3:0], bank_oe, bank_we
  function automatic logic [11:0] expect_out();
    logic [15:0] a;
    int   reg_i;
    logic s_read, s_write, grant;
    logic e_rom_ce, e_rom_oe, e_a12, e_cs, e_oe, e_we, e_boe, e_bwe;
    logic [3:0] e_bcs;
    a       = {s_addr_hi, 11'h000};
    reg_i   = region_of(a);
    s_read  = (s_mreq_n == 0) && (s_rd_n == 0) && (s_wr_n == 1);
    s_write = (s_mreq_n == 0) && (s_wr_n == 0);
    if (src_sub) begin
      e_rom_ce = !(reg_i == 0);
      e_rom_oe = !(reg_i == 0 && s_read);
      e_a12    = a[12];
      e_cs     = !(reg_i == 1);
      e_oe     = !(reg_i == 1 && s_read);
      e_we     = !(reg_i == 1 && s_write);
    end else begin
      grant    = (m_cram_req_n == 0) && (sub_rst_n == 1) && (sub_ack_n == 0);
      e_rom_ce = m_rom_req_n;
      e_rom_oe = !((m_rom_req_n == 0) && (m_rd_n == 0) && (m_wr_n == 1));
      e_a12    = 1'b1;
      e_cs     = !grant;
      e_oe     = !(grant && (m_rd_n == 0) && (m_wr_n == 1));
      e_we     = !(grant && (m_wr_n == 0));
    end
    for (int k = 0; k < 4; k++)
      e_bcs[k] = !(reg_i == k + 2 && (s_read || s_write));
    e_boe = !(reg_i >= 2 && s_read);
    e_bwe = !(reg_i >= 2 && s_write);
    return {e_rom_ce, e_rom_oe, e_a12, e_cs, e_oe, e_we, e_bcs, e_boe, e_bwe};
  endfunction

  task automatic check(input string req);
    logic [11:0] got, exp;
    @(negedge clk);
    got = {rom_ce_n, rom_oe_n, rom_a12, cram_cs_n, cram_oe_n, cram_we_n,
           bank_cs_n, bank_oe_n, bank_we_n};
    exp = expect_out();
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s src=%b addr_hi=%h got=%b expected=%b",
               req, src_sub, s_addr_hi, got, exp);
    end
  endtask

  task automatic set_idle();
    @(posedge clk);
    src_sub = 1'b1; m_rom_req_n = 1'b1; m_cram_req_n = 1'b1; m_rd_n = 1'b1; m_wr_n = 1'b1;
    sub_rst_n = 1'b1; sub_ack_n = 1'b1;
    s_addr_hi = 5'd12; s_mreq_n = 1'b1; s_rd_n = 1'b1; s_wr_n = 1'b1;
  endtask

  task automatic drive_sub(input logic [4:0] tag, input logic [2:0] strb);
    @(posedge clk);
    s_addr_hi = tag; s_mreq_n = strb[2]; s_rd_n = strb[1]; s_wr_n = strb[0];
  endtask

  task automatic string_for_region(input int r, output string s);
    case (r)
      0: s = "R5 sub ROM decode";
      1: s = "R6 sub common RAM decode";
      -1: s = "R8 unmapped area idle";
      default: s = "R7 private bank decode";
    endcase
  endtask

  // Reset/idle state: nothing requested, high address, all outputs inactive (R8).
  task automatic t_reset_state();
    set_idle();
    check("R8 reset idle outputs");
  endtask

  // Every 2 KB page against all request/strobe combinations, sub CPU owning (R5-R9).
  task automatic t_sub_sweep();
    string s;
    for (int t = 0; t < 32; t++) begin
      for (int c = 0; c < 8; c++) begin
        src_sub = 1'b1;
        drive_sub(5'(t), 3'(c));
        string_for_region(region_of({5'(t), 11'h000}), s);
        if (c[0] == 0 && c[1] == 0) s = {s, " R9 write priority"};
        check(s);
      end
    end
  endtask

  // All main CPU control combinations with the main CPU owning (R2, R3, R4, R9).
  task automatic t_main_sweep();
    for (int v = 0; v < 64; v++) begin
      @(posedge clk);
      src_sub = 1'b0;
      {m_rom_req_n, m_cram_req_n, m_rd_n, m_wr_n, sub_rst_n, sub_ack_n} = 6'(v);
      s_addr_hi = 5'd12; s_mreq_n = 1'b1; s_rd_n = 1'b1; s_wr_n = 1'b1;
      check("R2 R3 R4 main side controls");
    end
  endtask

  // Same stimulus on both sides, owner flipped (R1).
  task automatic t_source_switch();
    @(posedge clk);
    m_rom_req_n = 1'b1; m_cram_req_n = 1'b0; m_rd_n = 1'b1; m_wr_n = 1'b0;
    sub_rst_n = 1'b1; sub_ack_n = 1'b0;
    s_addr_hi = 5'd4; s_mreq_n = 1'b0; s_rd_n = 1'b0; s_wr_n = 1'b1;
    src_sub = 1'b0;
    check("R1 main owns common RAM write");
    @(posedge clk); src_sub = 1'b1;
    check("R1 sub owns common RAM read");
    @(posedge clk); s_addr_hi = 5'd1; src_sub = 1'b0;
    check("R1 main owner with sub in ROM");
    @(posedge clk); src_sub = 1'b1;
    check("R1 sub ROM read with a12 from address");
  endtask

  // Private banks keep working while the main CPU owns the shared memories (R10).
  task automatic t_bank_independent();
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        @(posedge clk);
        src_sub = 1'(s);
        m_rom_req_n = 1'b0; m_cram_req_n = 1'b0; m_rd_n = 1'b0; m_wr_n = 1'b1;
        sub_rst_n = 1'b1; sub_ack_n = 1'b0;
        s_addr_hi = 5'(8 + k); s_mreq_n = 1'b0; s_rd_n = 1'(k[0]); s_wr_n = 1'(~k[0]);
        check("R10 bank outputs independent of owner");
      end
    end
  endtask

  // Window edges given as full addresses (R5, R6, R7, R8).
  task automatic t_boundaries();
    logic [15:0] edges [10] = '{16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF,
                                16'h4000, 16'h47FF, 16'h5FFF, 16'h6000, 16'hFFFF};
    for (int i = 0; i < 10; i++) begin
      src_sub = 1'b1;
      drive_sub(edges[i][15:11], 3'b001);
      check("R5 R6 R7 R8 window edge");
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog R1 expired cycles=%0d expected<=%0d", cycles, 20000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    src_sub = 1'b1; m_rom_req_n = 1'b1; m_cram_req_n = 1'b1; m_rd_n = 1'b1; m_wr_n = 1'b1;
    sub_rst_n = 1'b1; sub_ack_n = 1'b1;
    s_addr_hi = 5'd12; s_mreq_n = 1'b1; s_rd_n = 1'b1; s_wr_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset_state();
    @(posedge clk); rst = 1'b0;
    t_sub_sweep();
    t_main_sweep();
    t_source_switch();
    t_bank_independent();
    t_boundaries();
    t_reset_state();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule